// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This bridge is a memory-mapped bus slave that sits in front of two fixed 1 MB backing regions. Each region has a 32 MB alias window in which every 32-bit alias word stands for one bit of backing memory. An alias read is turned into one backing read. The selected bit comes back as 0 or 1. An alias write is turned into a locked read-modify-write that sets or clears just that bit and leaves its neighbours as they were.

The alias side is a single-outstanding request/response port. It takes an address, a write flag, an access size (byte, halfword or word) and write data. The backing side is a master port with byte enables on a 32-bit little-endian data bus. The master port has an acknowledge input that completes each access. The access size sets how wide the backing access is and where its address is aligned. The alias offset gives both the backing byte address and the bit index within that access.

Top module: `bitband_bridge`

## Requirements
- R1: After reset `bus_ready_o` is 1, and both `mem_req_o` and `bus_rvalid_o` are 0.
- R2: An alias address whose bits [31:25] match window 0x22000000 targets backing base 0x20000000, and one matching 0x42000000 targets 0x40000000. The backing byte address is the base ORed with alias bits [24:5] placed at bits [19:0].
- R3: The size code is 0 for byte, 1 for halfword and 2 for word. A byte access keeps the backing address as computed and enables lane address[1:0]. A halfword access clears address bit 0 and enables lanes 1:0 or 3:2 according to address bit 1. A word access clears address bits [1:0] and enables all four lanes.
- R4: An alias read makes exactly one backing read and no backing write. Its response returns in bit 0 the value of the selected backing bit, and bits [31:1] of the response are zero. The bit index is alias offset bits [4:2] within the byte for a byte access, (offset>>2) mod 16 within the halfword, and (offset>>2) mod 32 within the word. Lanes are little-endian.
- R5: An alias write makes one backing read, then one backing write, at the same address and byte enables. The written word equals the word read, with the selected bit set when write-data bit 0 is 1 and cleared otherwise.
- R6: Alias write-data bits [31:1] have no effect on the stored result.
- R7: From the accepting edge until the response, `bus_ready_o` stays 0 and no other alias request is accepted. A request held valid meanwhile is served only after the current read-modify-write has finished its backing write.
- R8: `bus_rvalid_o` rises in the cycle after the final backing acknowledge and stays high for exactly one cycle. The final acknowledge is the read's for a read and the write's for a write.
- R9: An alias address outside both windows is answered with data 0 and makes no backing access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Alias request valid |
| bus_ready_o | output | 1 | Bridge idle, request accepted when valid |
| bus_addr_i | input | 32 | Alias byte address |
| bus_write_i | input | 1 | 1 for a write, 0 for a read |
| bus_size_i | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_wdata_i | input | 32 | Write data, bit 0 is the new bit value |
| bus_rvalid_o | output | 1 | One-cycle response strobe |
| bus_rdata_o | output | 32 | Response data, selected bit in bit 0 |
| mem_req_o | output | 1 | Backing access request, held until acknowledged |
| mem_we_o | output | 1 | Backing access is a write |
| mem_addr_o | output | 32 | Backing byte address |
| mem_be_o | output | 4 | Backing byte-lane enables |
| mem_wdata_o | output | 32 | Backing write data |
| mem_ack_i | input | 1 | Backing access complete, read data valid |
| mem_rdata_i | input | 32 | Backing read data |

## Verification
Two functions can meet in one cycle: accepting a new alias request, and finishing the locked read-modify-write of the previous one. The test provokes this by keeping the request valid straight after a write is accepted, with the address changed to a read of the same bit, against a backing memory that stalls each access for several cycles. It passes when ready stays low on every busy cycle and the backing access log reads read, write, read. The second request must also return the bit value that the first one just wrote.

// File: rtl/bb_pkg.sv
package bb_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;
  localparam int POS_W  = $clog2(DATA_W);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } bb_size_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD,
    S_MOD,
    S_WR,
    S_RSP
  } bb_state_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [BE_W-1:0]   be;
    logic [POS_W-1:0]  pos;
    logic              write;
    logic              set;
    logic              hit;
  } bb_cmd_t;
endpackage

// File: rtl/bb_region_decode.sv
module bb_region_decode
  import bb_pkg::*;
#(
  parameter int NUM_REG = 2,
  parameter int WIN_BITS = 25,
  parameter logic [NUM_REG-1:0][ADDR_W-1:0] ALIAS_BASE = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NUM_REG-1:0][ADDR_W-1:0] BACK_BASE  = {32'h4000_0000, 32'h2000_0000}
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [NUM_REG-1:0] hit_o,
  output logic [ADDR_W-1:0]  base_o
);
  generate
    for (genvar g = 0; g < NUM_REG; g++) begin : g_win
      assign hit_o[g] = (addr_i[ADDR_W-1:WIN_BITS] == ALIAS_BASE[g][ADDR_W-1:WIN_BITS]);
    end
  endgenerate

  always_comb begin
    base_o = '0;
    for (int i = 0; i < NUM_REG; i++) begin
      if (hit_o[i]) base_o = base_o | BACK_BASE[i];
    end
  end

  logic unused_low;
  assign unused_low = ^addr_i[WIN_BITS-1:0];
endmodule

// File: rtl/bb_lane_map.sv
module bb_lane_map
  import bb_pkg::*;
#(
  parameter int WIN_BITS = 25
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  bb_size_e          size_i,
  output logic [ADDR_W-1:0] baddr_o,
  output logic [BE_W-1:0]   be_o,
  output logic [POS_W-1:0]  pos_o
);
  localparam int SHIFT = $clog2(DATA_W);

  logic [WIN_BITS-1:0] off;
  logic [ADDR_W-1:0]   raw;

  assign off = addr_i[WIN_BITS-1:0];
  assign raw = base_i | ADDR_W'(off >> SHIFT);

  // little-endian lanes: bus bit = lane*8 + bit-in-access
  always_comb begin
    case (size_i)
      SZ_BYTE: begin
        baddr_o = raw;
        be_o    = BE_W'(1) << raw[1:0];
        pos_o   = {raw[1:0], off[4:2]};
      end
      SZ_HALF: begin
        baddr_o = {raw[ADDR_W-1:1], 1'b0};
        be_o    = raw[1] ? 4'b1100 : 4'b0011;
        pos_o   = {raw[1], off[5:2]};
      end
      default: begin
        baddr_o = {raw[ADDR_W-1:2], 2'b00};
        be_o    = '1;
        pos_o   = off[6:2];
      end
    endcase
  end

  logic unused_off;
  assign unused_off = ^off[1:0];
endmodule

// File: rtl/bb_rmw_ctrl.sv
module bb_rmw_ctrl
  import bb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  output logic              bus_ready_o,
  input  bb_cmd_t           cmd_i,
  output logic              bus_rvalid_o,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BE_W-1:0]   mem_be_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  bb_state_e         state_q;
  bb_cmd_t           cmd_q;
  logic [DATA_W-1:0] rd_q;
  logic [DATA_W-1:0] wd_q;
  logic              rbit_q;
  logic [DATA_W-1:0] bit_mask;

  assign bit_mask = DATA_W'(1) << cmd_q.pos;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cmd_q   <= '0;
      rd_q    <= '0;
      wd_q    <= '0;
      rbit_q  <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (bus_valid_i) begin
          cmd_q   <= cmd_i;
          rbit_q  <= 1'b0;
          state_q <= cmd_i.hit ? S_RD : S_RSP;
        end
        S_RD: if (mem_ack_i) begin
          rd_q <= mem_rdata_i;
          if (cmd_q.write) begin
            state_q <= S_MOD;
          end else begin
            rbit_q  <= mem_rdata_i[cmd_q.pos];
            state_q <= S_RSP;
          end
        end
        S_MOD: begin
          wd_q    <= cmd_q.set ? (rd_q | bit_mask) : (rd_q & ~bit_mask);
          state_q <= S_WR;
        end
        S_WR:    if (mem_ack_i) state_q <= S_RSP;
        S_RSP:   state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign bus_ready_o  = (state_q == S_IDLE);
  assign bus_rvalid_o = (state_q == S_RSP);
  assign bus_rdata_o  = {{(DATA_W-1){1'b0}}, rbit_q};
  assign mem_req_o    = (state_q == S_RD) || (state_q == S_WR);
  assign mem_we_o     = (state_q == S_WR);
  assign mem_addr_o   = cmd_q.addr;
  assign mem_be_o     = cmd_q.be;
  assign mem_wdata_o  = wd_q;

  p_no_accept_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !bus_ready_o);
  p_req_held_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_be_o)));
  p_modify_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_o) |-> $past(!mem_req_o));
  p_rsp_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rvalid_o |=> !bus_rvalid_o);
  p_rsp_zero_ext_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rvalid_o |-> (bus_rdata_o[DATA_W-1:1] == '0));
  p_be_shape_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> ($countones(mem_be_o) == 1 || $countones(mem_be_o) == 2 || $countones(mem_be_o) == 4));
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
  import bb_pkg::*;
#(
  parameter int NUM_REG = 2,
  parameter int WIN_BITS = 25,
  parameter logic [NUM_REG-1:0][ADDR_W-1:0] ALIAS_BASE = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NUM_REG-1:0][ADDR_W-1:0] BACK_BASE  = {32'h4000_0000, 32'h2000_0000}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  output logic              bus_ready_o,
  input  logic [31:0]       bus_addr_i,
  input  logic              bus_write_i,
  input  logic [1:0]        bus_size_i,
  input  logic [31:0]       bus_wdata_i,
  output logic              bus_rvalid_o,
  output logic [31:0]       bus_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [31:0]       mem_addr_o,
  output logic [3:0]        mem_be_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i
);
  logic [NUM_REG-1:0] hit_vec;
  logic [ADDR_W-1:0]  back_base;
  logic [ADDR_W-1:0]  baddr;
  logic [BE_W-1:0]    be;
  logic [POS_W-1:0]   pos;
  bb_cmd_t            cmd;

  bb_region_decode #(
    .NUM_REG(NUM_REG), .WIN_BITS(WIN_BITS),
    .ALIAS_BASE(ALIAS_BASE), .BACK_BASE(BACK_BASE)
  ) u_dec (
    .addr_i(bus_addr_i),
    .hit_o (hit_vec),
    .base_o(back_base)
  );

  bb_lane_map #(.WIN_BITS(WIN_BITS)) u_lane (
    .addr_i (bus_addr_i),
    .base_i (back_base),
    .size_i (bb_size_e'(bus_size_i)),
    .baddr_o(baddr),
    .be_o   (be),
    .pos_o  (pos)
  );

  always_comb begin
    cmd.addr  = baddr;
    cmd.be    = be;
    cmd.pos   = pos;
    cmd.write = bus_write_i;
    cmd.set   = bus_wdata_i[0];
    cmd.hit   = |hit_vec;
  end

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata_i[DATA_W-1:1];

  bb_rmw_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_valid_i (bus_valid_i),
    .bus_ready_o (bus_ready_o),
    .cmd_i       (cmd),
    .bus_rvalid_o(bus_rvalid_o),
    .bus_rdata_o (bus_rdata_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_be_o    (mem_be_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i)
  );

  p_one_window_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));
endmodule

// File: tb/tb_bitband_bridge.sv
`timescale 1ns/1ps
module tb_bitband_bridge;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_valid_i = 1'b0;
  logic        bus_ready_o;
  logic [31:0] bus_addr_i = '0;
  logic        bus_write_i = 1'b0;
  logic [1:0]  bus_size_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic        bus_rvalid_o;
  logic [31:0] bus_rdata_o;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic [3:0]  mem_be_o;
  logic        mem_ack_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  bitband_bridge dut (.*);

  // backing memory model
  logic [31:0] mem_m [bit [31:0]];
  int  mem_lat = 0, wait_cnt = 0;
  int  n_rd = 0, n_wr = 0;
  logic [31:0] last_rd_addr, last_wr_addr;
  logic [3:0]  last_rd_be, last_wr_be;
  bit  ack_last = 0, ack_last_we = 0, ack_we = 0;
  int  op_log [16];
  int  log_n = 0;

  function automatic logic [31:0] mrd(input logic [31:0] a);
    bit [31:0] k = {a[31:2], 2'b00};
    return mem_m.exists(k) ? mem_m[k] : 32'h0;
  endfunction

  always @(negedge clk_i) begin
    ack_last    = mem_ack_i;
    ack_last_we = ack_we;
    if (mem_ack_i) begin
      mem_ack_i = 1'b0;
    end else if (mem_req_o) begin
      if (wait_cnt < mem_lat) wait_cnt++;
      else begin
        wait_cnt  = 0;
        mem_ack_i = 1'b1;
        ack_we    = mem_we_o;
        if (log_n < 16) op_log[log_n] = mem_we_o ? 1 : 0;
        log_n++;
        if (mem_we_o) begin
          logic [31:0] w;
          w = mrd(mem_addr_o);
          for (int l = 0; l < 4; l++) if (mem_be_o[l]) w[8*l +: 8] = mem_wdata_o[8*l +: 8];
          mem_m[{mem_addr_o[31:2], 2'b00}] = w;
          n_wr++; last_wr_addr = mem_addr_o; last_wr_be = mem_be_o;
        end else begin
          mem_rdata_i = mrd(mem_addr_o);
          n_rd++; last_rd_addr = mem_addr_o; last_rd_be = mem_be_o;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference mapping written from the requirements
  function automatic logic [31:0] ref_raw(input logic [31:0] a);
    logic [31:0] base = (a[31:25] == 7'h11) ? 32'h2000_0000 : 32'h4000_0000;
    return base | ((a & 32'h01FF_FFFF) >> 5);
  endfunction
  function automatic logic [31:0] ref_addr(input logic [31:0] a, input logic [1:0] sz);
    logic [31:0] r = ref_raw(a);
    if (sz == 0) return r;
    if (sz == 1) return r & ~32'h1;
    return r & ~32'h3;
  endfunction
  function automatic logic [3:0] ref_be(input logic [31:0] a, input logic [1:0] sz);
    logic [31:0] r = ref_raw(a);
    if (sz == 0) return 4'b0001 << r[1:0];
    if (sz == 1) return r[1] ? 4'b1100 : 4'b0011;
    return 4'b1111;
  endfunction
  function automatic int ref_pos(input logic [31:0] a, input logic [1:0] sz);
    logic [31:0] r = ref_raw(a);
    int idx = int'((a & 32'h01FF_FFFF) >> 2);
    if (sz == 0) return int'(r[1:0]) * 8 + idx % 8;
    if (sz == 1) return int'(r[1]) * 16 + idx % 16;
    return idx % 32;
  endfunction

  task automatic do_acc(input logic [31:0] a, input bit w, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd, output bit ack_ok);
    @(negedge clk_i); #1;
    bus_valid_i = 1; bus_addr_i = a; bus_write_i = w; bus_size_i = sz; bus_wdata_i = wd;
    while (!bus_ready_o) begin @(negedge clk_i); #1; end
    @(negedge clk_i); #1;
    bus_valid_i = 0;
    while (!bus_rvalid_o) begin @(negedge clk_i); #1; end
    rd = bus_rdata_o;
    ack_ok = ack_last && (ack_last_we == w);
    @(negedge clk_i); #1;
    chk("R8 response lasts one cycle", {31'b0, bus_rvalid_o}, 32'h0);
  endtask

  task automatic t_reset;
    @(negedge clk_i); #1;
    chk("R1 ready after reset", {31'b0, bus_ready_o}, 32'h1);
    chk("R1 no backing request", {31'b0, mem_req_o}, 32'h0);
    chk("R1 no response", {31'b0, bus_rvalid_o}, 32'h0);
  endtask

  task automatic t_reads;
    logic [31:0] addrs [6] = '{32'h2200_202C, 32'h2200_0FFC, 32'h4200_1234,
                                32'h43FF_FFFC, 32'h2200_0000, 32'h4200_0060};
    logic [1:0]  sizes [6] = '{2'd0, 2'd1, 2'd2, 2'd2, 2'd0, 2'd1};
    mem_lat = 1;
    for (int i = 0; i < 6; i++) begin
      for (int v = 0; v < 2; v++) begin
        logic [31:0] a, rd, pat;
        bit ok;
        int wr0, p;
        a = addrs[i];
        p = ref_pos(a, sizes[i]);
        pat = (v == 1) ? (32'h1 << p) : ~(32'h1 << p);
        mem_m[{ref_addr(a, sizes[i])} & ~32'h3] = pat;
        wr0 = n_wr;
        do_acc(a, 0, sizes[i], 32'h0, rd, ok);
        chk("R4 read bit value", rd, 32'(v));
        chk("R2 backing address", last_rd_addr, ref_addr(a, sizes[i]));
        chk("R3 byte enables", {28'b0, last_rd_be}, {28'b0, ref_be(a, sizes[i])});
        chk("R4 read makes no write", 32'(n_wr - wr0), 32'h0);
        chk("R8 response after read ack", {31'b0, ok}, 32'h1);
      end
    end
  endtask

  task automatic t_writes;
    logic [31:0] addrs [4] = '{32'h2200_0124, 32'h4200_0F7C, 32'h2201_2345, 32'h43FF_FF80};
    logic [1:0]  sizes [4] = '{2'd0, 2'd1, 2'd2, 2'd0};
    mem_lat = 2;
    for (int i = 0; i < 4; i++) begin
      for (int v = 0; v < 2; v++) begin
        logic [31:0] a, rd, pat, exp, k;
        bit ok;
        int wr0, rd0;
        a = addrs[i];
        k = ref_addr(a, sizes[i]) & ~32'h3;
        pat = 32'hA5A5_5A5A;
        mem_m[k] = pat;
        exp = (v == 1) ? (pat | (32'h1 << ref_pos(a, sizes[i]))) : (pat & ~(32'h1 << ref_pos(a, sizes[i])));
        wr0 = n_wr; rd0 = n_rd;
        do_acc(a, 1, sizes[i], 32'(v), rd, ok);
        chk("R5 stored word", mrd(k), exp);
        chk("R5 one read one write", 32'((n_rd - rd0) * 16 + (n_wr - wr0)), 32'h11);
        chk("R5 write address equals read address", last_wr_addr, last_rd_addr);
        chk("R5 write lanes equal read lanes", {28'b0, last_wr_be}, {28'b0, ref_be(a, sizes[i])});
        chk("R8 response after write ack", {31'b0, ok}, 32'h1);
      end
    end
  endtask

  task automatic t_wdata_ignored;
    logic [31:0] a, rd, k;
    bit ok;
    a = 32'h4200_0208;  // word access, bit 2 of word 0x40000010
    k = 32'h4000_0010;
    mem_m[k] = 32'h0000_0004;
    do_acc(a, 1, 2'd2, 32'hFFFF_FFFE, rd, ok);
    chk("R6 upper wdata bits do not set", mrd(k), 32'h0);
    do_acc(a, 1, 2'd2, 32'h8000_0001, rd, ok);
    chk("R6 upper wdata bits do not disturb", mrd(k), 32'h0000_0004);
  endtask

  task automatic t_miss;
    logic [31:0] rd;
    bit ok;
    int c0;
    c0 = n_rd + n_wr;
    do_acc(32'h3000_0010, 0, 2'd2, 32'h0, rd, ok);
    chk("R9 miss returns zero", rd, 32'h0);
    do_acc(32'h2400_0004, 1, 2'd0, 32'h1, rd, ok);
    chk("R9 miss makes no backing access", 32'(n_rd + n_wr - c0), 32'h0);
  endtask

  task automatic t_locked;
    logic [31:0] a, rd;
    int busy_ready;
    a = 32'h2200_0000 + (32'h40 << 5) + (5 << 2);  // byte 0x20000040, bit 5
    mem_m[32'h2000_0040] = 32'h0;
    mem_lat = 3;
    log_n = 0;
    busy_ready = 0;
    @(negedge clk_i); #1;
    bus_valid_i = 1; bus_addr_i = a; bus_write_i = 1; bus_size_i = 2'd0; bus_wdata_i = 32'h1;
    while (!bus_ready_o) begin @(negedge clk_i); #1; end
    @(negedge clk_i); #1;
    bus_write_i = 0; bus_wdata_i = 32'h0;  // second request held valid
    while (!bus_rvalid_o) begin
      if (bus_ready_o) busy_ready++;
      @(negedge clk_i); #1;
    end
    chk("R7 ready low while busy", 32'(busy_ready), 32'h0);
    chk("R7 second request not yet issued", 32'(log_n), 32'h2);
    while (!bus_ready_o) begin @(negedge clk_i); #1; end
    @(negedge clk_i); #1;
    bus_valid_i = 0;
    while (!bus_rvalid_o) begin @(negedge clk_i); #1; end
    rd = bus_rdata_o;
    chk("R7 access order", 32'(op_log[0] * 4 + op_log[1] * 2 + op_log[2]), 32'h2);
    chk("R7 held read sees written bit", rd, 32'h1);
    chk("R5 locked write stored", mrd(32'h2000_0040), 32'h0000_0020);
    mem_lat = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_reads();
    t_writes();
    t_wdata_ignored();
    t_miss();
    t_locked();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule